// File: doc/BRIEF.md
# Prescaled Square-Wave Interrupt Output Timer

This block drives one external interrupt output line from a single control word. A free-running prescaler divides the bus clock into slow ticks, 520 bus clocks per tick by default. A tick counter then compares against a programmable half-period limit. When the mode field holds the toggle code, the output level inverts once every (limit + 1) ticks, giving a square wave with a full period of 2 x (limit + 1) ticks.

Software can measure the bus clock against an independent time base. It programs a known limit, samples the live level bit in the read-back word and times its rising edges. Writing an all-zero word returns the block to its power-on state. Every write restarts the prescaler and the tick counter, so the first half period after a write always has full length. The pad driver is enabled only when both a separate output-enable input and a direction input are high.

Top module: `irq_wave_gen`

## Requirements
- R1: After reset the read-back word is all zero, the live level is low and the pad enable is low.
- R2: A tick occurs once every PRESCALE bus clocks (default 520). The prescaler restarts from zero on every write, so the first tick falls PRESCALE clocks after the write edge.
- R3: With mode field = 3'h7 (toggle), the level inverts every (COUNT + 1) ticks. The first inversion is seen PRESCALE x (COUNT + 1) clock edges after the write edge, and each later inversion follows the same distance.
- R4: Writing the all-zero word stops the counter, forces the level low at the write edge and reads back as zero.
- R5: Any mode value other than 3'h7 holds the level low and keeps the counter stopped.
- R6: A write during a running wave clears the level to low and restarts counting, so the next inversion comes a full half period after that write.
- R7: The read-back word holds COUNT in bits [15:0], MODE in bits [18:16], DIAG in bits [20:19] and the live level in bit 31, with all other bits zero. DIAG is stored and read back with no effect on the waveform. Bit 31 of a write is ignored.
- R8: pad_oe is high exactly when both out_en and dir_sel are high. pad_out always equals the live level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Strobe that loads wr_data into the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Control word fields plus the live level in bit 31 |
| out_en | input | 1 | Output-enable control for the pad |
| dir_sel | input | 1 | Direction control for the pad (1 = output) |
| pad_out | output | 1 | Square-wave level sent to the pad |
| pad_oe | output | 1 | Pad driver enable |

## Verification
The case that is hardest to reach from the ports is a rewrite that lands partway through a half period. The prescaler and tick counter then hold nonzero state that a stale implementation would carry over. The stimulus lets a wave with COUNT = 1 run for several hundred clocks, rewrites the same word, and checks that the next inversion arrives a full 1040 clocks later rather than at the old phase. A sweep of COUNT from 0 to 3 counts the clock edges between consecutive level changes and compares each count with 520 x (COUNT + 1).

// File: rtl/irq_wave_pkg.sv
package irq_wave_pkg;
   localparam int unsigned MODE_W = 3;
   localparam logic [MODE_W-1:0] MODE_TOGGLE = 3'h7;
endpackage

// File: rtl/irq_wave_prescaler.sv
module irq_wave_prescaler #(
   parameter int unsigned PRESCALE = 520
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   initial begin
      if (PRESCALE < 1) $error("PRESCALE must be at least 1");
   end

   generate
      if (PRESCALE == 1) begin : g_pass
         assign tick = ~clr;
      end else begin : g_div
         localparam int unsigned PW = $clog2(PRESCALE);
         localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);
         logic [PW-1:0] div_q;

         always_ff @(posedge clk) begin
            if (!rst_n || clr) div_q <= '0;
            else if (div_q == LAST) div_q <= '0;
            else div_q <= div_q + 1'b1;
         end

         assign tick = (div_q == LAST) && !clr;

         AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick); // R2
      end
   endgenerate
endmodule

// File: rtl/irq_wave_halfcnt.sv
module irq_wave_halfcnt #(
   parameter int unsigned COUNT_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               tick,
   input  logic [COUNT_W-1:0] limit,
   output logic               wrap
);
   logic [COUNT_W-1:0] cnt_q;

   assign wrap = tick && !clr && (cnt_q == limit);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) cnt_q <= '0;
      else if (wrap) cnt_q <= '0;
      else if (tick) cnt_q <= cnt_q + 1'b1;
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (cnt_q <= limit)); // R3
endmodule

// File: rtl/irq_wave_gen.sv
module irq_wave_gen
   import irq_wave_pkg::*;
#(
   parameter int unsigned PRESCALE = 520,
   parameter int unsigned COUNT_W  = 16,
   parameter int unsigned DIAG_W   = 2,
   parameter int unsigned DATA_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic              out_en,
   input  logic              dir_sel,
   output logic              pad_out,
   output logic              pad_oe
);
   localparam int unsigned MODE_LSB  = COUNT_W;
   localparam int unsigned DIAG_LSB  = MODE_LSB + MODE_W;
   localparam int unsigned LEVEL_BIT = DATA_W - 1;

   initial begin
      if (DIAG_LSB + DIAG_W > LEVEL_BIT) $error("fields overlap the level bit");
      if (COUNT_W < 1) $error("COUNT_W must be positive");
   end

   logic [COUNT_W-1:0] count_q;
   logic [MODE_W-1:0]  mode_q;
   logic [DIAG_W-1:0]  diag_q;
   logic               level_q;
   logic               run, clr, tick, wrap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
         mode_q  <= '0;
         diag_q  <= '0;
      end else if (wr_en) begin
         count_q <= wr_data[COUNT_W-1:0];
         mode_q  <= wr_data[MODE_LSB +: MODE_W];
         diag_q  <= wr_data[DIAG_LSB +: DIAG_W];
      end
   end

   assign run = (mode_q == MODE_TOGGLE);
   assign clr = wr_en || !run;

   irq_wave_prescaler #(.PRESCALE(PRESCALE)) u_pre (
      .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick)
   );

   irq_wave_halfcnt #(.COUNT_W(COUNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick),
      .limit(count_q), .wrap(wrap)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || wr_en) level_q <= 1'b0;
      else if (wrap) level_q <= ~level_q;
   end

   always_comb begin
      rd_data = '0;
      rd_data[COUNT_W-1:0]        = count_q;
      rd_data[MODE_LSB +: MODE_W] = mode_q;
      rd_data[DIAG_LSB +: DIAG_W] = diag_q;
      rd_data[LEVEL_BIT]          = level_q;
   end

   assign pad_out = level_q;
   assign pad_oe  = out_en & dir_sel;

   AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != MODE_TOGGLE) |-> !level_q); // R5
   AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !level_q); // R6
   AST_TOGGLE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(level_q)) |-> ($past(tick) || $past(wr_en))); // R3
endmodule

// File: tb/sim_irq_wave_gen.sv
module sim_irq_wave_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        out_en = 1'b0;
   logic        dir_sel = 1'b0;
   logic        pad_out, pad_oe;
   int          total = 0;
   int          bad = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   irq_wave_gen u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .out_en(out_en), .dir_sel(dir_sel),
      .pad_out(pad_out), .pad_oe(pad_oe)
   );

   task automatic check(input string req, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [31:0] d);
      @(negedge clk);
      wr_data = d;
      wr_en   = 1'b1;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   function automatic logic [31:0] word(input int cnt, input int mode, input int diag);
      return 32'(cnt) | (32'(mode) << 16) | (32'(diag) << 19);
   endfunction

   // clock edges until the level changes, capped
   task automatic measure(output int n);
      logic prev = rd_data[31];
      n = 0;
      while (n < 5000) begin
         @(negedge clk);
         n++;
         if (rd_data[31] != prev) break;
      end
   endtask

   initial begin
      int n;
      repeat (4) @(negedge clk);
      check("R1 reset word", rd_data, 0);
      check("R1 pad_oe", pad_oe, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 R2 sweep of COUNT 0..3, two half periods each
      for (int c = 0; c < 4; c++) begin
         wr(word(c, 7, 0));
         measure(n);
         check("R3 first half", n, 520 * (c + 1));
         check("R3 level high", rd_data[31], 1);
         measure(n);
         check("R2 second half", n, 520 * (c + 1));
      end

      // R7 field readback, DIAG without effect, bit31 ignored
      wr(word(2, 7, 3) | 32'h8000_0000);
      check("R7 readback", rd_data, word(2, 7, 3));
      measure(n);
      check("R7 diag no effect", n, 1560);

      // R8 pad gating and pad_out follows level
      for (int i = 0; i < 4; i++) begin
         out_en  = i[0];
         dir_sel = i[1];
         #1;
         check("R8 pad_oe", pad_oe, (i == 3) ? 1 : 0);
         check("R8 pad_out", pad_out, rd_data[31]);
      end

      // R4 write zero while high
      check("R4 precondition high", rd_data[31], 1);
      wr(32'h0);
      check("R4 zero word", rd_data, 0);
      repeat (1200) @(negedge clk);
      check("R4 stays stopped", rd_data[31], 0);

      // R5 non-toggle mode
      wr(word(0, 5, 1));
      repeat (1200) @(negedge clk);
      check("R5 held low", rd_data[31], 0);
      check("R5 readback", rd_data, word(0, 5, 1));

      // R6 rewrite mid half period restarts
      wr(word(1, 7, 0));
      measure(n);
      check("R6 ref half", n, 1040);
      repeat (700) @(negedge clk);
      wr(word(1, 7, 0));
      check("R6 level cleared", rd_data[31], 0);
      measure(n);
      check("R6 full half after rewrite", n, 1040);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (150000) @(posedge clk);
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
         end
      join_any
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule